// File: doc/BRIEF.md
# Dual-Half 128-Bit General Register File

This block holds the 32 general registers of a core that can execute in 32-bit, 64-bit or 128-bit mode. Every register is kept as two separate 64-bit halves, a low half and a high half, so that narrower cores can leave the high half out of their datapath. Two read ports each return both halves of one register combinationally. One write port stores either the low half alone or both halves together.

A low-only write shapes its data by the current mode: in 32-bit mode the low half gets the sign extension of bit 31, otherwise the data is stored unchanged. When the core's maximum width is 128 bits, the same write also refills the high half with copies of bit 63 of the new low half. This keeps every register a correctly sign-extended 128-bit value. A full write stores both halves at once and is honoured only in 128-bit mode. The high half is visible on the read ports only in 128-bit mode. A high-half read requested in any other mode raises an error flag.

Top module: `dual_half_regfile`

## Requirements
- R1: Register 0 reads as zero on both halves and on both ports, and a write of either kind to register 0 leaves every register unchanged.
- R2: A low-only write (`wr_full`=0) in 32-bit mode (`cur_mode`=2'b01) stores bit 31 of `wr_lo` copied into bits 63:32 above `wr_lo[31:0]`.
- R3: A low-only write in 64-bit mode (`cur_mode`=2'b10, and the reserved code 2'b00 behaves the same) or in 128-bit mode (`cur_mode`=2'b11) stores `wr_lo` unchanged in the low half.
- R4: When `max_mode`=2'b11, every low-only write to a nonzero register also sets the high half to 64 copies of bit 63 of the low value actually stored. When `max_mode` is any other code, a low-only write leaves the high half unchanged.
- R5: A full write (`wr_full`=1) in 128-bit mode stores `wr_lo` and `wr_hi` into the two halves at the same clock edge.
- R6: A full write while `cur_mode` is not 2'b11 changes no register.
- R7: The `rd_hi_*` outputs carry the stored high half when `cur_mode`=2'b11 and are zero otherwise. `hi_read_err` is 1 in exactly the cycles where `rd_hi_req_a` or `rd_hi_req_b` is 1 while `cur_mode` is not 2'b11.
- R8: Writes take effect at the rising clock edge. A read of the register being written in the same cycle returns the old value.
- R9: While `rst_n` is low at a rising edge, every register is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_mode | input | 2 | Operating width: 01=32, 10=64, 11=128, 00 treated as 64 |
| max_mode | input | 2 | Static maximum supported width, same encoding |
| rd_addr_a | input | 5 | Read port A register index |
| rd_hi_req_a | input | 1 | Port A consumer needs the high half |
| rd_lo_a | output | 64 | Port A low half |
| rd_hi_a | output | 64 | Port A high half (zero outside 128-bit mode) |
| rd_addr_b | input | 5 | Read port B register index |
| rd_hi_req_b | input | 1 | Port B consumer needs the high half |
| rd_lo_b | output | 64 | Port B low half |
| rd_hi_b | output | 64 | Port B high half (zero outside 128-bit mode) |
| wr_en | input | 1 | Write request |
| wr_full | input | 1 | 1 = full 128-bit write, 0 = low-only write |
| wr_addr | input | 5 | Write register index |
| wr_lo | input | 64 | Low-half write data |
| wr_hi | input | 64 | High-half data for a full write |
| hi_read_err | output | 1 | High half requested outside 128-bit mode |

## Verification
The bench builds the block with its default parameters: 32 registers and 64-bit halves. This puts the 32-bit sign boundary at bit 31 and the high-half fill at bit 63 within reach of directed values. The bench changes `max_mode` between scenarios. This exposes both the filled and the untouched high half, because a full write can store a pattern that a later low-only write with a 64-bit maximum must leave in place.

// File: rtl/rf128_pkg.sv
// Package: shared mode encoding for the dual-half register file.
// Assumes a two-bit width code; the reserved code is treated as 64-bit.
package rf128_pkg;
    typedef enum logic [1:0] {
        XL_RSVD = 2'b00,
        XL_32   = 2'b01,
        XL_64   = 2'b10,
        XL_128  = 2'b11
    } xl_e;
endpackage

// File: rtl/rf_wr_shape.sv
// Module: rf_wr_shape
// Turns one write request into per-half write enables and data.
// Applies narrow sign extension, high-half refill and full-write gating.
// Assumes index 0 is the hard-wired zero register.
module rf_wr_shape #(
    parameter int HALF_W   = 64,
    parameter int NARROW_W = 32,
    parameter int AW       = 5
) (
    input  logic              wr_en,
    input  logic              wr_full,
    input  logic [AW-1:0]     wr_addr,
    input  logic [HALF_W-1:0] wr_lo,
    input  logic [HALF_W-1:0] wr_hi,
    input  logic [1:0]        cur_mode,
    input  logic [1:0]        max_mode,
    output logic              lo_we,
    output logic              hi_we,
    output logic [HALF_W-1:0] lo_wdata,
    output logic [HALF_W-1:0] hi_wdata
);
    import rf128_pkg::*;

    localparam int EXT_W = HALF_W - NARROW_W;

    logic target_ok;
    logic mode_128;
    logic mode_32;
    logic max_128;

    // Decode the mode inputs and the zero-register target.
    always_comb begin
        target_ok = (wr_addr != '0);
        mode_128  = (xl_e'(cur_mode) == XL_128);
        mode_32   = (xl_e'(cur_mode) == XL_32);
        max_128   = (xl_e'(max_mode) == XL_128);
    end

    // Select enables and data for the two halves.
    always_comb begin
        if (wr_full) begin
            lo_we    = wr_en && target_ok && mode_128;
            hi_we    = wr_en && target_ok && mode_128;
            lo_wdata = wr_lo;
            hi_wdata = wr_hi;
        end else begin
            lo_we    = wr_en && target_ok;
            lo_wdata = mode_32 ? {{EXT_W{wr_lo[NARROW_W-1]}}, wr_lo[NARROW_W-1:0]} : wr_lo;
            hi_we    = wr_en && target_ok && max_128;
            hi_wdata = {HALF_W{lo_wdata[HALF_W-1]}};
        end
    end
endmodule

// File: rtl/rf_half_bank.sv
// Module: rf_half_bank
// One half of every register: NREGS words of W bits, a single write
// port and two combinational read ports. Entry 0 is constant zero.
// Assumes the caller never needs a bypass from the write port.
module rf_half_bank #(
    parameter int NREGS = 32,
    parameter int W     = 64,
    parameter int AW    = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b
);
    logic [W-1:0] mem [NREGS];

    for (genvar i = 0; i < NREGS; i++) begin : g_entry
        if (i == 0) begin : g_zero
            assign mem[i] = '0;
        end else begin : g_word
            logic [W-1:0] q;
            // Hold one word; clear on reset, load on a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (we && waddr == AW'(i)) begin
                    q <= wdata;
                end
            end
            assign mem[i] = q;
        end
    end

    // Combinational read of both ports.
    always_comb begin
        rdata_a = mem[raddr_a];
        rdata_b = mem[raddr_b];
    end

    // R5
    bank_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr != '0) |=> (mem[$past(waddr)] == $past(wdata)));

    // R9
    bank_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (mem[NREGS-1] == '0));
endmodule

// File: rtl/rf_read_guard.sv
// Module: rf_read_guard
// Masks high-half read data outside 128-bit mode and flags any
// high-half request made in that state. Purely combinational.
module rf_read_guard #(
    parameter int HALF_W = 64
) (
    input  logic [1:0]        cur_mode,
    input  logic              hi_req_a,
    input  logic              hi_req_b,
    input  logic [HALF_W-1:0] hi_in_a,
    input  logic [HALF_W-1:0] hi_in_b,
    output logic [HALF_W-1:0] hi_out_a,
    output logic [HALF_W-1:0] hi_out_b,
    output logic              err
);
    import rf128_pkg::*;

    logic wide;

    // Gate the high halves and raise the error flag.
    always_comb begin
        wide     = (xl_e'(cur_mode) == XL_128);
        hi_out_a = wide ? hi_in_a : '0;
        hi_out_b = wide ? hi_in_b : '0;
        err      = (hi_req_a || hi_req_b) && !wide;
    end
endmodule

// File: rtl/dual_half_regfile.sv
// Module: dual_half_regfile (top)
// 32-entry register file with separately stored 64-bit halves, two
// read ports and one write port (low-only or full). Assumes cur_mode
// never exceeds max_mode and that max_mode is static in normal use.
module dual_half_regfile #(
    parameter int NREGS  = 32,
    parameter int HALF_W = 64,
    parameter int AW     = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cur_mode,
    input  logic [1:0]        max_mode,
    input  logic [AW-1:0]     rd_addr_a,
    input  logic              rd_hi_req_a,
    output logic [HALF_W-1:0] rd_lo_a,
    output logic [HALF_W-1:0] rd_hi_a,
    input  logic [AW-1:0]     rd_addr_b,
    input  logic              rd_hi_req_b,
    output logic [HALF_W-1:0] rd_lo_b,
    output logic [HALF_W-1:0] rd_hi_b,
    input  logic              wr_en,
    input  logic              wr_full,
    input  logic [AW-1:0]     wr_addr,
    input  logic [HALF_W-1:0] wr_lo,
    input  logic [HALF_W-1:0] wr_hi,
    output logic              hi_read_err
);
    logic              lo_we;
    logic              hi_we;
    logic [HALF_W-1:0] lo_wdata;
    logic [HALF_W-1:0] hi_wdata;
    logic [HALF_W-1:0] hi_raw_a;
    logic [HALF_W-1:0] hi_raw_b;

    rf_wr_shape #(.HALF_W(HALF_W), .NARROW_W(32), .AW(AW)) u_shape (
        .wr_en    (wr_en),
        .wr_full  (wr_full),
        .wr_addr  (wr_addr),
        .wr_lo    (wr_lo),
        .wr_hi    (wr_hi),
        .cur_mode (cur_mode),
        .max_mode (max_mode),
        .lo_we    (lo_we),
        .hi_we    (hi_we),
        .lo_wdata (lo_wdata),
        .hi_wdata (hi_wdata)
    );

    rf_half_bank #(.NREGS(NREGS), .W(HALF_W), .AW(AW)) u_lo_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (lo_we),
        .waddr   (wr_addr),
        .wdata   (lo_wdata),
        .raddr_a (rd_addr_a),
        .raddr_b (rd_addr_b),
        .rdata_a (rd_lo_a),
        .rdata_b (rd_lo_b)
    );

    rf_half_bank #(.NREGS(NREGS), .W(HALF_W), .AW(AW)) u_hi_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (hi_we),
        .waddr   (wr_addr),
        .wdata   (hi_wdata),
        .raddr_a (rd_addr_a),
        .raddr_b (rd_addr_b),
        .rdata_a (hi_raw_a),
        .rdata_b (hi_raw_b)
    );

    rf_read_guard #(.HALF_W(HALF_W)) u_guard (
        .cur_mode (cur_mode),
        .hi_req_a (rd_hi_req_a),
        .hi_req_b (rd_hi_req_b),
        .hi_in_a  (hi_raw_a),
        .hi_in_b  (hi_raw_b),
        .hi_out_a (rd_hi_a),
        .hi_out_b (rd_hi_b),
        .err      (hi_read_err)
    );

    // R1
    zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_a == '0) |-> (rd_lo_a == '0 && rd_hi_a == '0));

    // R7
    hi_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode != 2'b11) |-> (rd_hi_a == '0 && rd_hi_b == '0));

    // R7
    hi_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_hi_req_a || rd_hi_req_b) && cur_mode != 2'b11) |-> hi_read_err);

    // R6
    full_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_full && cur_mode != 2'b11 && rd_addr_a == wr_addr)
        |=> (rd_lo_a == $past(rd_lo_a)) || (rd_addr_a != $past(rd_addr_a)));

    // R4
    hi_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_we && !wr_full) |-> (hi_wdata == {HALF_W{lo_wdata[HALF_W-1]}}) && lo_we);
endmodule

// File: tb/dual_half_regfile_tb.sv
`timescale 1ns/1ps
module dual_half_regfile_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cur_mode = 2'b11;
    logic [1:0]  max_mode = 2'b11;
    logic [4:0]  rd_addr_a = '0;
    logic        rd_hi_req_a = 1'b0;
    logic [63:0] rd_lo_a;
    logic [63:0] rd_hi_a;
    logic [4:0]  rd_addr_b = '0;
    logic        rd_hi_req_b = 1'b0;
    logic [63:0] rd_lo_b;
    logic [63:0] rd_hi_b;
    logic        wr_en = 1'b0;
    logic        wr_full = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [63:0] wr_lo = '0;
    logic [63:0] wr_hi = '0;
    logic        hi_read_err;

    int total = 0;
    int bad = 0;
    logic [63:0] m_lo [32];
    logic [63:0] m_hi [32];

    always #2.5 clk = ~clk;

    dual_half_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .cur_mode(cur_mode), .max_mode(max_mode),
        .rd_addr_a(rd_addr_a), .rd_hi_req_a(rd_hi_req_a), .rd_lo_a(rd_lo_a), .rd_hi_a(rd_hi_a),
        .rd_addr_b(rd_addr_b), .rd_hi_req_b(rd_hi_req_b), .rd_lo_b(rd_lo_b), .rd_hi_b(rd_hi_b),
        .wr_en(wr_en), .wr_full(wr_full), .wr_addr(wr_addr), .wr_lo(wr_lo), .wr_hi(wr_hi),
        .hi_read_err(hi_read_err)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model update from the requirements, then one write cycle.
    task automatic do_write(input logic full, input logic [4:0] a,
                            input logic [63:0] lo, input logic [63:0] hi);
        logic [63:0] nlo;
        @(negedge clk);
        wr_en = 1'b1; wr_full = full; wr_addr = a; wr_lo = lo; wr_hi = hi;
        if (a != 0) begin
            if (full) begin
                if (cur_mode == 2'b11) begin m_lo[a] = lo; m_hi[a] = hi; end
            end else begin
                nlo = (cur_mode == 2'b01) ? {{32{lo[31]}}, lo[31:0]} : lo;
                m_lo[a] = nlo;
                if (max_mode == 2'b11) m_hi[a] = {64{nlo[63]}};
            end
        end
        @(negedge clk);
        wr_en = 1'b0; wr_full = 1'b0;
    endtask

    task automatic check_reg(input string req, input logic [4:0] a);
        rd_addr_a = a; rd_addr_b = a;
        #1;
        chk(req, rd_lo_a, m_lo[a]);
        chk(req, rd_lo_b, m_lo[a]);
        chk(req, rd_hi_a, (cur_mode == 2'b11) ? m_hi[a] : 64'h0);
        chk(req, rd_hi_b, (cur_mode == 2'b11) ? m_hi[a] : 64'h0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 32; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
    endtask

    task automatic t_reset();   // R9
        do_write(1'b1, 5'd9, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888);
        do_reset();
        cur_mode = 2'b11;
        for (int i = 0; i < 32; i++) check_reg("R9", 5'(i));
    endtask

    task automatic t_zero();    // R1
        cur_mode = 2'b11;
        do_write(1'b1, 5'd0, 64'hdead_beef_dead_beef, 64'hcafe_cafe_cafe_cafe);
        do_write(1'b0, 5'd0, 64'hffff_ffff_ffff_ffff, 64'h0);
        check_reg("R1", 5'd0);
        check_reg("R1", 5'd1);
    endtask

    task automatic t_narrow32();  // R2, R4
        max_mode = 2'b11; cur_mode = 2'b01;
        do_write(1'b0, 5'd3, 64'h0123_4567_8000_1234, 64'h0);
        check_reg("R2", 5'd3);
        do_write(1'b0, 5'd4, 64'hffff_0000_7fff_ffff, 64'h0);
        check_reg("R2", 5'd4);
        cur_mode = 2'b11;
        check_reg("R4", 5'd3);
        check_reg("R4", 5'd4);
    endtask

    task automatic t_low64();   // R3, R4
        max_mode = 2'b11; cur_mode = 2'b10;
        do_write(1'b0, 5'd5, 64'h8000_0000_0000_0001, 64'h0);
        do_write(1'b0, 5'd6, 64'h7fff_ffff_ffff_fffe, 64'h0);
        cur_mode = 2'b00;
        do_write(1'b0, 5'd7, 64'h0000_0000_ffff_ffff, 64'h0);
        check_reg("R3", 5'd7);
        cur_mode = 2'b11;
        do_write(1'b0, 5'd8, 64'h9abc_def0_1234_5678, 64'h0);
        check_reg("R3", 5'd5);
        check_reg("R4", 5'd6);
        check_reg("R3", 5'd8);
    endtask

    task automatic t_full();    // R5, R6
        max_mode = 2'b11; cur_mode = 2'b11;
        do_write(1'b1, 5'd10, 64'h0f0f_0f0f_0f0f_0f0f, 64'hf0f0_f0f0_f0f0_f0f0);
        check_reg("R5", 5'd10);
        cur_mode = 2'b10;
        do_write(1'b1, 5'd10, 64'haaaa_aaaa_aaaa_aaaa, 64'h5555_5555_5555_5555);
        cur_mode = 2'b11;
        check_reg("R6", 5'd10);
    endtask

    task automatic t_max64();   // R4
        max_mode = 2'b11; cur_mode = 2'b11;
        do_write(1'b1, 5'd12, 64'h1, 64'h1234_5678_9abc_def0);
        max_mode = 2'b10; cur_mode = 2'b10;
        do_write(1'b0, 5'd12, 64'hffff_ffff_ffff_ffff, 64'h0);
        max_mode = 2'b11; cur_mode = 2'b11;
        check_reg("R4", 5'd12);
    endtask

    task automatic t_err();     // R7
        cur_mode = 2'b11; rd_hi_req_a = 1'b1; rd_hi_req_b = 1'b1;
        #1 chk("R7", 64'(hi_read_err), 64'h0);
        cur_mode = 2'b10; rd_hi_req_b = 1'b0;
        #1 chk("R7", 64'(hi_read_err), 64'h1);
        cur_mode = 2'b01; rd_hi_req_a = 1'b0; rd_hi_req_b = 1'b1;
        #1 chk("R7", 64'(hi_read_err), 64'h1);
        rd_hi_req_b = 1'b0;
        #1 chk("R7", 64'(hi_read_err), 64'h0);
        rd_addr_a = 5'd10;
        #1 chk("R7", rd_hi_a, 64'h0);
        cur_mode = 2'b11;
    endtask

    task automatic t_same_cycle();  // R8
        max_mode = 2'b11; cur_mode = 2'b11;
        do_write(1'b1, 5'd20, 64'h0000_0000_0000_00aa, 64'h0000_0000_0000_00bb);
        @(negedge clk);
        wr_en = 1'b1; wr_full = 1'b1; wr_addr = 5'd20;
        wr_lo = 64'h0000_0000_0000_0011; wr_hi = 64'h0000_0000_0000_0022;
        rd_addr_a = 5'd20; rd_addr_b = 5'd20;
        #1;
        chk("R8", rd_lo_a, 64'haa);
        chk("R8", rd_hi_b, 64'hbb);
        @(posedge clk);
        #1;
        chk("R8", rd_lo_a, 64'h11);
        chk("R8", rd_hi_b, 64'h22);
        m_lo[20] = 64'h11; m_hi[20] = 64'h22;
        @(negedge clk);
        wr_en = 1'b0; wr_full = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_zero();
        t_narrow32();
        t_low64();
        t_full();
        t_max64();
        t_err();
        t_same_cycle();
        t_reset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule